// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Traps

This block collects event pulses from peripheral sources and from a small set of trap sources, keeps a sticky pending flag for each, and presents one request at a time to the CPU. Every peripheral source has an enable bit and a 3-bit priority field. Traps have fixed priorities from level 8 upward and cannot be masked. The request that is offered is the most urgent eligible one. It comes with a vector index and the level it would run at.

The CPU accepts a request with an acknowledge pulse. On acknowledge, the block saves the current CPU priority level on an internal stack and raises the level to that of the request. A return pulse pops the saved level. Software works through a small register port. Through it, software sets and clears flags, programs enables and priorities, clears trap flags, writes the CPU level, selects no-nesting mode and starts a timed disable. The timed disable holds back user levels 1 to 6 for a programmed number of cycles.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset every user priority field reads 4 (address 2, 3 bits per source, source i at bits 3i+2:3i). Flags, enables, trap flags, the no-nesting bit, the disable count and the CPU level all read 0, and no request is raised.
- R2: A user source i is eligible only when its flag (address 0, bit i) and its enable (address 1, bit i) are both set, its priority is non-zero, and its priority is strictly above the CPU level. A priority of 0 never requests.
- R3: Among eligible user sources the highest priority wins, and on a tie the lowest index wins. The vector is N_TRAP+i, and irq_lvl_o carries the source's priority.
- R4: Trap k runs at level 8+k and has vector k. It is eligible whenever its flag is set and 8+k exceeds the CPU level. The timed disable and no-nesting never block it. Any eligible trap beats every user source, and the highest eligible trap index wins.
- R5: While the CPU level is 7 or more, no user source is requested.
- R6: Writing a count C to address 5 masks user levels 1 to 6 for the next C cycles. The count drops by one per cycle and reads back at address 5. Level 7 still passes. A write while the count is running reloads it.
- R7: A user flag stays set until software writes it clear through address 0 (the whole flag vector is written, and a same-cycle event pulse wins). A flag still set after a return requests again at once.
- R8: With the no-nesting bit set (address 4, bit 0) and the level stack non-empty, no user source is requested.
- R9: A trap flag stays set until a 1 is written to its bit at address 3.
- R10: An acknowledge of a raised request loads the CPU level with irq_lvl_o and pushes the old level. A return pops the saved level into the CPU level. Acknowledge takes precedence over return, and return takes precedence over a register write of the level (address 6, bits 3:0).
- R11: Registers written at addresses 0, 1, 2, 4 and 6 read back the written value at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_evt_i | input | N_SRC | Event pulses that set user flags |
| trap_evt_i | input | N_TRAP | Event pulses that set trap flags |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_req_o | output | 1 | Interrupt or trap requested |
| irq_vec_o | output | VEC_W | Vector of the request |
| irq_lvl_o | output | 4 | Level of the request |
| irq_ack_i | input | 1 | CPU takes the request |
| irq_ret_i | input | 1 | CPU returns from a handler |
| cpu_lvl_o | output | 4 | Current CPU priority level |

## Verification
The bench uses the default build: eight user sources, four traps and an 8-bit disable count. With eight sources, ties at every priority and full-priority mixes appear often. With four traps, the trap levels reach 8 through 11, so traps preempt one another and also preempt user handlers. Disable counts are kept short, so expiry and reload happen many times within the random run. Random lowering of the CPU level while handlers are active drives the level stack deep.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W  = 4;
  localparam int PRIO_W = 3;
  localparam int DW     = 32;
  localparam int AW     = 3;
  localparam int STK_D  = 1 << LVL_W;

  localparam logic [AW-1:0] A_FLAG = 3'd0;
  localparam logic [AW-1:0] A_EN   = 3'd1;
  localparam logic [AW-1:0] A_PRIO = 3'd2;
  localparam logic [AW-1:0] A_TRAP = 3'd3;
  localparam logic [AW-1:0] A_CTRL = 3'd4;
  localparam logic [AW-1:0] A_DIS  = 3'd5;
  localparam logic [AW-1:0] A_LVL  = 3'd6;

  localparam logic [PRIO_W-1:0] PRIO_RST = 3'd4;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_evt_i,
  input  logic [N_TRAP-1:0]       trap_evt_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [N_SRC-1:0]        flag_o,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o,
  output logic [N_TRAP-1:0]       trap_o,
  output logic                    no_nest_o
);
  localparam int PW = N_SRC * PRIO_W;

  logic [N_SRC-1:0]  flag_q, en_q;
  logic [PW-1:0]     prio_q;
  logic [N_TRAP-1:0] trap_q;
  logic              nn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      prio_q <= {N_SRC{PRIO_RST}};
      trap_q <= '0;
      nn_q   <= 1'b0;
    end else begin
      flag_q <= ((we_i && addr_i == A_FLAG) ? wdata_i[N_SRC-1:0] : flag_q) | src_evt_i;
      trap_q <= ((we_i && addr_i == A_TRAP) ? (trap_q & ~wdata_i[N_TRAP-1:0]) : trap_q)
                | trap_evt_i;
      if (we_i && addr_i == A_EN)   en_q   <= wdata_i[N_SRC-1:0];
      if (we_i && addr_i == A_PRIO) prio_q <= wdata_i[PW-1:0];
      if (we_i && addr_i == A_CTRL) nn_q   <= wdata_i[0];
    end
  end

  assign flag_o    = flag_q;
  assign en_o      = en_q;
  assign prio_o    = prio_q;
  assign trap_o    = trap_q;
  assign no_nest_o = nn_q;

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  a_r9_trap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_TRAP) |=> ((trap_q & $past(trap_q)) == $past(trap_q)));
endmodule

// File: rtl/irq_dis_timer.sv
module irq_dis_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign active_o = (cnt_q != '0);

  a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !load_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             ret_i,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  output logic [LVL_W-1:0] cpu_lvl_o,
  output logic             nested_o
);
  localparam int SP_W = $clog2(STK_D);

  logic [LVL_W-1:0] stk_q [STK_D];
  logic [SP_W:0]    sp_q;
  logic [SP_W:0]    sp_dec;
  logic [LVL_W-1:0] lvl_q;

  assign sp_dec = sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      lvl_q <= '0;
      for (int i = 0; i < STK_D; i++) stk_q[i] <= '0;
    end else if (ack_i) begin
      if (sp_q < (SP_W+1)'(STK_D)) begin
        stk_q[sp_q[SP_W-1:0]] <= lvl_q;
        sp_q <= sp_q + 1'b1;
      end
      lvl_q <= ack_lvl_i;
    end else if (ret_i && sp_q != '0) begin
      lvl_q <= stk_q[sp_dec[SP_W-1:0]];
      sp_q  <= sp_dec;
    end else if (wr_i) begin
      lvl_q <= wr_lvl_i;
    end
  end

  assign cpu_lvl_o = lvl_q;
  assign nested_o  = (sp_q != '0);

  a_r10_ack_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (cpu_lvl_o == $past(ack_lvl_i)));
  a_r10_ack_nests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> nested_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int VEC_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        flag_i,
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [N_TRAP-1:0]       trap_i,
  input  logic [LVL_W-1:0]        cpu_lvl_i,
  input  logic                    dis_i,
  input  logic                    no_nest_i,
  input  logic                    nested_i,
  output logic                    req_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [LVL_W-1:0]        lvl_o
);
  logic              u_ok, t_ok, ok;
  logic [PRIO_W-1:0] p, u_p;
  logic [VEC_W-1:0]  u_v, t_v;
  logic [LVL_W-1:0]  t_l;

  always_comb begin
    u_ok = 1'b0; u_p = '0; u_v = '0; p = '0; ok = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      p  = prio_i[i*PRIO_W +: PRIO_W];
      ok = flag_i[i] && en_i[i] && (p != '0) && ({1'b0, p} > cpu_lvl_i)
           && !(dis_i && p != 3'd7) && !(no_nest_i && nested_i);
      // strict compare keeps the lowest index on ties
      if (ok && (!u_ok || p > u_p)) begin
        u_ok = 1'b1;
        u_p  = p;
        u_v  = VEC_W'(N_TRAP + i);
      end
    end
    t_ok = 1'b0; t_l = '0; t_v = '0;
    for (int k = 0; k < N_TRAP; k++) begin
      if (trap_i[k] && LVL_W'(8 + k) > cpu_lvl_i) begin
        t_ok = 1'b1;
        t_l  = LVL_W'(8 + k);
        t_v  = VEC_W'(k);
      end
    end
    req_o = t_ok || u_ok;
    vec_o = t_ok ? t_v : u_v;
    lvl_o = t_ok ? t_l : {1'b0, u_p};
  end

  a_r2_above_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (lvl_o > cpu_lvl_i));
  a_r5_lvl7_traps_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cpu_lvl_i >= 4'd7) |-> (lvl_o >= 4'd8));
  a_r6_dis_pass7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && dis_i && lvl_o < 4'd8) |-> (lvl_o == 4'd7));
  a_r4_trap_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && lvl_o >= 4'd8) |-> (vec_o < VEC_W'(N_TRAP)));
  a_r8_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && no_nest_i && nested_i) |-> (lvl_o >= 4'd8));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int CNT_W  = 8,
  localparam int VEC_W = $clog2(N_SRC + N_TRAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic [N_TRAP-1:0] trap_evt_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  input  logic              irq_ack_i,
  input  logic              irq_ret_i,
  output logic [LVL_W-1:0]  cpu_lvl_o
);
  logic [N_SRC-1:0]        flag, en;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic [N_TRAP-1:0]       trap;
  logic                    no_nest, nested, dis_on;
  logic [CNT_W-1:0]        dis_cnt;
  logic [LVL_W-1:0]        cpu_lvl;

  irq_src_regs #(.N_SRC(N_SRC), .N_TRAP(N_TRAP)) i_regs (
    .clk_i, .rst_ni, .src_evt_i, .trap_evt_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_o(flag), .en_o(en), .prio_o(prio), .trap_o(trap), .no_nest_o(no_nest)
  );

  irq_dis_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i(reg_we_i && reg_addr_i == A_DIS), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .cnt_o(dis_cnt), .active_o(dis_on)
  );

  irq_lvl_stack i_stack (
    .clk_i, .rst_ni,
    .ack_i(irq_ack_i && irq_req_o), .ack_lvl_i(irq_lvl_o),
    .ret_i(irq_ret_i),
    .wr_i(reg_we_i && reg_addr_i == A_LVL), .wr_lvl_i(reg_wdata_i[LVL_W-1:0]),
    .cpu_lvl_o(cpu_lvl), .nested_o(nested)
  );

  irq_arbiter #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .VEC_W(VEC_W)) i_arb (
    .clk_i, .rst_ni,
    .flag_i(flag), .en_i(en), .prio_i(prio), .trap_i(trap),
    .cpu_lvl_i(cpu_lvl), .dis_i(dis_on), .no_nest_i(no_nest), .nested_i(nested),
    .req_o(irq_req_o), .vec_o(irq_vec_o), .lvl_o(irq_lvl_o)
  );

  assign cpu_lvl_o = cpu_lvl;

  always_comb begin
    case (reg_addr_i)
      A_FLAG:  reg_rdata_o = DW'(flag);
      A_EN:    reg_rdata_o = DW'(en);
      A_PRIO:  reg_rdata_o = DW'(prio);
      A_TRAP:  reg_rdata_o = DW'(trap);
      A_CTRL:  reg_rdata_o = DW'(no_nest);
      A_DIS:   reg_rdata_o = DW'(dis_cnt);
      A_LVL:   reg_rdata_o = DW'(cpu_lvl);
      default: reg_rdata_o = '0;
    endcase
  end

  a_r10_ret_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) ##1 (irq_ret_i && !(irq_ack_i && irq_req_o))
      |=> (cpu_lvl_o == $past(cpu_lvl_o, 2)));
endmodule

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
  localparam int CLK_P  = 10;
  localparam int N_SRC  = 8;
  localparam int N_TRAP = 4;
  localparam int CNT_W  = 8;
  localparam int VEC_W  = $clog2(N_SRC + N_TRAP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  src_evt = '0;
  logic [N_TRAP-1:0] trap_evt = '0;
  logic              we = 1'b0;
  logic [2:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              req;
  logic [VEC_W-1:0]  vec;
  logic [3:0]        lvl;
  logic              ack = 1'b0;
  logic              ret = 1'b0;
  logic [3:0]        cpu_lvl;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [7:0]  m_flag, m_en, m_cnt;
  logic [23:0] m_prio;
  logic [3:0]  m_trap, m_lvl;
  logic        m_nn;
  int          m_sp;
  int          m_stk [16];

  always #(CLK_P/2) clk = ~clk;

  irq_ctrl_top #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .CNT_W(CNT_W)) i_irq_ctrl_top (
    .clk_i(clk), .rst_ni(rst_n), .src_evt_i(src_evt), .trap_evt_i(trap_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_vec_o(vec), .irq_lvl_o(lvl),
    .irq_ack_i(ack), .irq_ret_i(ret), .cpu_lvl_o(cpu_lvl)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_flag = '0; m_en = '0; m_cnt = '0; m_prio = {8{3'd4}};
    m_trap = '0; m_lvl = '0; m_nn = 1'b0; m_sp = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = 0;
  endtask

  task automatic model_arb(output bit r, output int v, output int l);
    int best_p; bit u_ok;
    r = 0; v = 0; l = 0; best_p = 0; u_ok = 0;
    for (int i = 0; i < N_SRC; i++) begin
      int p;
      p = int'(m_prio[3*i +: 3]);
      if (m_flag[i] && m_en[i] && p != 0 && p > int'(m_lvl) && !(m_cnt != 0 && p != 7)
          && !(m_nn && m_sp != 0) && (!u_ok || p > best_p)) begin
        u_ok = 1; best_p = p; v = N_TRAP + i;
      end
    end
    if (u_ok) begin r = 1; l = best_p; end
    for (int k = 0; k < N_TRAP; k++)
      if (m_trap[k] && (8 + k) > int'(m_lvl)) begin r = 1; v = k; l = 8 + k; end
  endtask

  function automatic int model_read(logic [2:0] a);
    case (a)
      3'd0: return int'(m_flag);
      3'd1: return int'(m_en);
      3'd2: return int'(m_prio);
      3'd3: return int'(m_trap);
      3'd4: return int'(m_nn);
      3'd5: return int'(m_cnt);
      3'd6: return int'(m_lvl);
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit r; int v, l;
    model_arb(r, v, l);
    m_flag = ((we && addr == 3'd0) ? wdata[7:0] : m_flag) | src_evt;
    m_trap = ((we && addr == 3'd3) ? (m_trap & ~wdata[3:0]) : m_trap) | trap_evt;
    if (we && addr == 3'd1) m_en = wdata[7:0];
    if (we && addr == 3'd2) m_prio = wdata[23:0];
    if (we && addr == 3'd4) m_nn = wdata[0];
    if (we && addr == 3'd5) m_cnt = wdata[7:0];
    else if (m_cnt != 0) m_cnt = m_cnt - 8'd1;
    if (ack && r) begin
      if (m_sp < 16) begin m_stk[m_sp] = int'(m_lvl); m_sp++; end
      m_lvl = 4'(l);
    end else if (ret && m_sp > 0) begin
      m_sp--; m_lvl = 4'(m_stk[m_sp]);
    end else if (we && addr == 3'd6) begin
      m_lvl = wdata[3:0];
    end
  endtask

  // one clock with current inputs; compare with model afterwards
  task automatic tick(string tag);
    bit r; int v, l;
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 1'b0; src_evt = '0; trap_evt = '0; ack = 1'b0; ret = 1'b0;
    #1;
    model_arb(r, v, l);
    chk(tag, "req", int'(req), int'(r));
    if (r) begin
      chk(tag, "vec", int'(vec), v);
      chk(tag, "lvl", int'(lvl), l);
    end
    chk(tag, "cpu_lvl", int'(cpu_lvl), int'(m_lvl));
    chk(tag, "rdata", int'(rdata), model_read(addr));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    we = 1'b1; addr = a; wdata = d; tick(tag);
  endtask
  task automatic rd(logic [2:0] a, int exp, string tag);
    addr = a; #1; chk(tag, "read", int'(rdata), exp);
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  function automatic logic [23:0] pk(int p0, int p1, int p2, int p3,
                                     int p4, int p5, int p6, int p7);
    return {3'(p7), 3'(p6), 3'(p5), 3'(p4), 3'(p3), 3'(p2), 3'(p1), 3'(p0)};
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(3'd2, 24'h924924, "R1");
    rd(3'd0, 0, "R1");
    rd(3'd5, 0, "R1");
    chk("R1", "req", int'(req), 0);
    chk("R1", "cpu_lvl", int'(cpu_lvl), 0);

    wr(3'd1, 32'hFF, "R11");
    rd(3'd1, 8'hFF, "R11");
    // R2 single source at default level
    src_evt = 8'h08; tick("R2");
    chk("R2", "req", int'(req), 1);
    chk("R2", "vec", int'(vec), 7);
    chk("R2", "lvl", int'(lvl), 4);
    idle(3, "R7");
    rd(3'd0, 8'h08, "R7");
    // R10 acknowledge loads level
    ack = 1'b1; tick("R10");
    chk("R10", "cpu_lvl", int'(cpu_lvl), 4);
    chk("R2", "req at equal level", int'(req), 0);
    // R3 tie at level 6: sources 1 and 5, source 2 at 5
    wr(3'd2, {8'h0, pk(4, 6, 5, 4, 4, 6, 4, 4)}, "R11");
    rd(3'd2, int'(pk(4, 6, 5, 4, 4, 6, 4, 4)), "R11");
    src_evt = 8'h26; tick("R3");
    chk("R3", "vec", int'(vec), 5);
    chk("R3", "lvl", int'(lvl), 6);
    // R8 no nesting while nested
    wr(3'd4, 32'h1, "R8");
    chk("R8", "req", int'(req), 0);
    wr(3'd4, 32'h0, "R8");
    chk("R8", "req released", int'(req), 1);
    ack = 1'b1; tick("R10");
    chk("R10", "cpu_lvl", int'(cpu_lvl), 6);
    ret = 1'b1; tick("R10");
    chk("R10", "restored", int'(cpu_lvl), 4);
    ret = 1'b1; tick("R10");
    chk("R10", "restored", int'(cpu_lvl), 0);
    chk("R7", "re-request", int'(req), 1);
    chk("R7", "vec", int'(vec), 5);
    wr(3'd0, 32'h0, "R7");
    chk("R7", "cleared", int'(req), 0);
    // R2 priority zero never requests
    wr(3'd2, {8'h0, pk(0, 4, 4, 4, 4, 4, 7, 4)}, "R2");
    src_evt = 8'h01; tick("R2");
    chk("R2", "prio0", int'(req), 0);
    // R6 timed disable
    wr(3'd2, {8'h0, pk(3, 4, 4, 4, 4, 4, 7, 4)}, "R6");
    chk("R6", "req", int'(req), 1);
    wr(3'd5, 32'd5, "R6");
    rd(3'd5, 5, "R6");
    chk("R6", "masked", int'(req), 0);
    src_evt = 8'h40; tick("R6");
    chk("R6", "level7 passes", int'(req), 1);
    chk("R6", "vec", int'(vec), 10);
    wr(3'd0, 32'h01, "R6");
    chk("R6", "masked again", int'(req), 0);
    idle(1, "R6");
    wr(3'd5, 32'd3, "R6");
    rd(3'd5, 3, "R6");
    idle(2, "R6");
    chk("R6", "still masked", int'(req), 0);
    idle(1, "R6");
    chk("R6", "released", int'(req), 1);
    chk("R6", "vec", int'(vec), 4);
    // R5 level 7 blocks users; R4 traps pass
    wr(3'd6, 32'd7, "R5");
    chk("R5", "req", int'(req), 0);
    wr(3'd4, 32'h1, "R4");
    wr(3'd5, 32'd20, "R4");
    trap_evt = 4'b0101; tick("R4");
    chk("R4", "req", int'(req), 1);
    chk("R4", "vec", int'(vec), 2);
    chk("R4", "lvl", int'(lvl), 10);
    ack = 1'b1; tick("R4");
    chk("R4", "cpu_lvl", int'(cpu_lvl), 10);
    chk("R4", "no self preempt", int'(req), 0);
    ret = 1'b1; tick("R9");
    chk("R9", "trap again", int'(vec), 2);
    wr(3'd3, 32'h4, "R9");
    chk("R9", "next trap", int'(vec), 0);
    chk("R9", "lvl", int'(lvl), 8);
    wr(3'd3, 32'h1, "R9");
    chk("R9", "no trap", int'(req), 0);

    // random phase from a fresh reset
    @(negedge clk); rst_n = 1'b0; model_reset();
    @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      bit r; int v, l; int sel;
      model_arb(r, v, l);
      if ($urandom % 4 == 0) src_evt = 8'(1 << ($urandom % 8));
      if ($urandom % 40 == 0) trap_evt = 4'(1 << ($urandom % 4));
      addr = 3'($urandom % 7);
      if ($urandom % 4 == 0) begin
        we = 1'b1;
        sel = int'(addr);
        case (sel)
          5: wdata = $urandom % 12;
          6: wdata = $urandom % 8;
          3: wdata = 32'(1 << ($urandom % 4));
          default: wdata = $urandom;
        endcase
      end
      ack = r && ($urandom % 3 == 0);
      ret = !ack && ($urandom % 5 == 0);
      tick("R3");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule